// File: doc/BRIEF.md
# Tick-Sampled Key Validator with Queue and Stall Watchdog

This block takes a key code and a pressed flag that are sampled once per system tick. It accepts a key only when two tick samples in a row show the same code pressed. Each accepted code goes into a small first-in, first-out queue. A consumer reads the queue through a show-ahead port. While the consumer is busy, new keys keep arriving in the queue, so no press is lost until the queue fills.

When the queue is full, any further accepted key is dropped, and a one-clock alarm pulse marks the drop. The block also supervises the consumer. If the queue stays non-empty for a set number of ticks and no entry is read in that time, the block raises a one-clock reset request for the system.

Top module: `key_queue_guard`

## Requirements
- R1: Key inputs are looked at only in cycles where `tick` is high. A code is accepted on the second of two consecutive tick samples that both have `key_down` high with the same `key_code`. The accepted code is visible at `rd_data` in the cycle after that tick edge.
- R2: `rd_valid` is high exactly when the queue holds an entry. `rd_data` shows the oldest entry. A cycle with `rd_en` high and `rd_valid` high removes that entry, and entries leave in the order they were accepted.
- R3: The queue holds up to DEPTH entries (default 8), and all of them are returned in order.
- R4: An accepted key that arrives while DEPTH entries are queued and no read happens in the same cycle is discarded. `full_alarm` is then high for exactly one clock, in the cycle after that tick edge. At all other times it is low.
- R5: When the queue has been non-empty with no read for STALL_TICKS ticks in a row, `wdog_rst` goes high for exactly one clock, after the tick that completes the count. The count then starts again.
- R6: A key held with an unchanged code is accepted only once. A tick sample with `key_down` low, or with a different code, is needed before the same code can be accepted again.
- R7: If a read and an accepted key fall in the same cycle while the queue is full, the key is stored and `full_alarm` stays low.
- R8: The stall count returns to zero in any cycle with a read, and whenever the queue is empty.
- R9: After reset the queue is empty, and `rd_valid`, `full_alarm` and `wdog_rst` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock sampling strobe |
| key_down | input | 1 | Key-pressed flag sampled on tick |
| key_code | input | KEY_W | Code of the pressed key |
| rd_en | input | 1 | Consumer read strobe |
| rd_data | output | KEY_W | Oldest queued code |
| rd_valid | output | 1 | Queue non-empty |
| full_alarm | output | 1 | One-clock pulse per discarded key |
| wdog_rst | output | 1 | One-clock system reset request on stall |

## Verification
The bench applies tick-by-tick stimulus and keeps a model of the validator state, the queue contents and the stall count. Every cycle it compares `rd_valid`, `rd_data`, `full_alarm` and `wdog_rst` against that model.

A validator in the wrong state shows up at once. It either queues a duplicate or misses a press, and the fault appears at `rd_data` or `rd_valid` one cycle after the tick. A wrong pointer or occupancy count in the queue shows up as a wrong head code on the next read, or as a missing or stray alarm the first time the queue fills.

A stall counter that is off by one, or fails to clear, moves the `wdog_rst` pulse by a whole tick. The directed stall runs catch that within STALL_TICKS ticks.

// File: rtl/kq_pkg.sv
package kq_pkg;

    // State of the key validator between tick samples
    typedef enum logic [1:0] {
        VAL_IDLE    = 2'd0,  // last sample: no key
        VAL_PENDING = 2'd1,  // last sample: key seen once, not yet accepted
        VAL_TAKEN   = 2'd2   // current hold already accepted
    } val_state_e;

    // Circular increment for queue pointers
    function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/kq_validator.sv
module kq_validator #(
    parameter int KEY_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             key_down,
    input  logic [KEY_W-1:0] key_code,
    output logic             accept,
    output logic [KEY_W-1:0] accept_code
);
    import kq_pkg::*;

    val_state_e       state_q, state_d;
    logic [KEY_W-1:0] last_q;
    logic             acc_d;

    always_comb begin
        state_d = state_q;
        acc_d   = 1'b0;
        if (tick) begin
            if (!key_down) begin
                state_d = VAL_IDLE;
            end else if (state_q == VAL_IDLE || key_code != last_q) begin
                state_d = VAL_PENDING;
            end else if (state_q == VAL_PENDING) begin
                state_d = VAL_TAKEN;
                acc_d   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= VAL_IDLE;
            last_q  <= '0;
        end else begin
            state_q <= state_d;
            if (tick && key_down) last_q <= key_code;
        end
    end

    assign accept      = acc_d;
    assign accept_code = key_code;

    AST_ACCEPT_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        accept |-> tick && key_down); // R1
    AST_SINGLE_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept |=> !accept); // R6
endmodule

// File: rtl/kq_queue.sv
module kq_queue #(
    parameter int KEY_W = 4,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [KEY_W-1:0] push_data,
    input  logic             rd_en,
    output logic [KEY_W-1:0] head,
    output logic             nonempty,
    output logic             pop,
    output logic             drop
);
    import kq_pkg::*;

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [KEY_W-1:0] mem [DEPTH];
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             full, store;

    assign full     = (count == CW'(DEPTH));
    assign nonempty = (count != '0);
    assign pop      = rd_en && nonempty;
    assign store    = push && (!full || pop);
    assign drop     = push && full && !pop;
    assign head     = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (store) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (store) wr_ptr <= PW'(wrap_inc(32'(wr_ptr), DEPTH));
            if (pop)   rd_ptr <= PW'(wrap_inc(32'(rd_ptr), DEPTH));
            case ({store, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH)); // R3
    AST_DROP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (rst)
        drop |=> $stable(count)); // R4
    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        (pop && !store) |=> (count == $past(count) - 1'b1)); // R2
    AST_FULL_SWAP: assert property (@(posedge clk) disable iff (rst)
        (full && pop && push) |=> (count == CW'(DEPTH))); // R7
endmodule

// File: rtl/kq_stall_watch.sv
module kq_stall_watch #(
    parameter int STALL_TICKS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic nonempty,
    input  logic pop,
    output logic fire
);
    localparam int SW = $clog2(STALL_TICKS + 1);

    logic [SW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            fire <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (!nonempty || pop) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt == SW'(STALL_TICKS - 1)) begin
                    cnt  <= '0;
                    fire <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    AST_STALL_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt < SW'(STALL_TICKS)); // R5
    AST_FIRE_PULSE: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire); // R5
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (pop || !nonempty) |=> (cnt == '0)); // R8
endmodule

// File: rtl/key_queue_guard.sv
module key_queue_guard #(
    parameter int KEY_W       = 4,
    parameter int DEPTH       = 8,
    parameter int STALL_TICKS = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             key_down,
    input  logic [KEY_W-1:0] key_code,
    input  logic             rd_en,
    output logic [KEY_W-1:0] rd_data,
    output logic             rd_valid,
    output logic             full_alarm,
    output logic             wdog_rst
);
    logic             accept, pop, drop;
    logic [KEY_W-1:0] accept_code;

    kq_validator #(.KEY_W(KEY_W)) u_val (
        .clk(clk), .rst(rst), .tick(tick), .key_down(key_down),
        .key_code(key_code), .accept(accept), .accept_code(accept_code)
    );

    kq_queue #(.KEY_W(KEY_W), .DEPTH(DEPTH)) u_q (
        .clk(clk), .rst(rst), .push(accept), .push_data(accept_code),
        .rd_en(rd_en), .head(rd_data), .nonempty(rd_valid),
        .pop(pop), .drop(drop)
    );

    kq_stall_watch #(.STALL_TICKS(STALL_TICKS)) u_wd (
        .clk(clk), .rst(rst), .tick(tick), .nonempty(rd_valid),
        .pop(pop), .fire(wdog_rst)
    );

    always_ff @(posedge clk) begin
        if (rst) full_alarm <= 1'b0;
        else     full_alarm <= drop;
    end

    AST_ALARM_PULSE: assert property (@(posedge clk) disable iff (rst)
        full_alarm |=> !full_alarm); // R4
    AST_ALARM_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
        full_alarm |-> rd_valid); // R4
endmodule

// File: tb/tb_key_queue_guard.sv
module tb_key_queue_guard;
    localparam int KW  = 4;
    localparam int DEP = 8;
    localparam int LIM = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0, key_down = 1'b0, rd_en = 1'b0;
    logic [KW-1:0] key_code = '0;
    logic [KW-1:0] rd_data;
    logic          rd_valid, full_alarm, wdog_rst;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [KW-1:0] mq[$];
    int            ms = 0;
    logic [KW-1:0] mcode = '0;
    int            mcnt = 0;
    logic [15:0]   lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    key_queue_guard #(.KEY_W(KW), .DEPTH(DEP), .STALL_TICKS(LIM)) dut (
        .clk(clk), .rst(rst), .tick(tick), .key_down(key_down),
        .key_code(key_code), .rd_en(rd_en), .rd_data(rd_data),
        .rd_valid(rd_valid), .full_alarm(full_alarm), .wdog_rst(wdog_rst)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock of stimulus, model update, then output comparison
    task automatic step(input string tag, input bit tk, input bit pr,
                        input logic [KW-1:0] cd, input bit rd);
        bit pop, acc, drop, fire;
        tick = tk; key_down = pr; key_code = cd; rd_en = rd;
        pop = rd && (mq.size() > 0);
        acc = 1'b0;
        if (tk) begin
            if (!pr) ms = 0;
            else if (ms == 0 || cd != mcode) begin ms = 1; mcode = cd; end
            else if (ms == 1) begin ms = 2; acc = 1'b1; end
        end
        fire = 1'b0;
        if (mq.size() == 0 || pop) mcnt = 0;
        else if (tk) begin
            if (mcnt == LIM - 1) begin fire = 1'b1; mcnt = 0; end
            else mcnt++;
        end
        drop = acc && (mq.size() == DEP) && !pop;
        if (pop) void'(mq.pop_front());
        if (acc && !drop) mq.push_back(cd);
        @(negedge clk);
        tick = 1'b0; rd_en = 1'b0;
        check({tag, " valid"}, 32'(rd_valid), 32'(mq.size() > 0));
        if (mq.size() > 0) check({tag, " data"}, 32'(rd_data), 32'(mq[0]));
        check({tag, " alarm"}, 32'(full_alarm), 32'(drop));
        check({tag, " wdog"}, 32'(wdog_rst), 32'(fire));
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog timeout");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        check("R9 valid", 32'(rd_valid), 0);
        check("R9 alarm", 32'(full_alarm), 0);
        check("R9 wdog", 32'(wdog_rst), 0);

        // R1: two matching tick samples, with non-tick noise between them
        step("R1", 1, 1, 4'h5, 0);
        check("R1 no early accept", 32'(rd_valid), 0);
        step("R1", 0, 1, 4'h7, 0);
        step("R1", 0, 0, 4'h0, 0);
        step("R1", 1, 1, 4'h5, 0);
        check("R1 accepted", 32'(rd_data), 32'h5);

        // R6: holding enqueues once; release re-arms
        for (int i = 0; i < 4; i++) step("R6", 1, 1, 4'h5, 0);
        check("R6 held once", 32'(mq.size()), 1);
        step("R6", 1, 0, 4'h0, 0);
        step("R6", 1, 1, 4'h5, 0);
        step("R6", 1, 1, 4'h5, 0);
        // R6: a code change re-arms without release
        step("R6", 1, 1, 4'h9, 0);
        step("R6", 1, 1, 4'h9, 0);
        check("R6 three queued", 32'(mq.size()), 3);
        for (int i = 0; i < 3; i++) step("R2", 0, 0, 4'h0, 1);
        check("R2 drained", 32'(rd_valid), 0);

        // R3 and R4: fill all DEPTH entries, then overflow
        for (int i = 0; i < DEP; i++) begin
            step("R3", 1, 1, 4'(i + 1), 0);
            step("R3", 1, 1, 4'(i + 1), 0);
            step("R3", 1, 0, 4'h0, 0);
        end
        check("R3 full", 32'(mq.size()), DEP);
        step("R4", 1, 1, 4'hE, 0);
        step("R4", 1, 1, 4'hE, 0);
        check("R4 alarm raised", 32'(full_alarm), 1);
        step("R4", 0, 0, 4'h0, 0);
        check("R4 alarm one clock", 32'(full_alarm), 0);
        // R7: full, read and accept in the same cycle
        step("R7", 1, 0, 4'h0, 0);
        step("R7", 1, 1, 4'hB, 0);
        step("R7", 1, 1, 4'hB, 1);
        check("R7 no alarm", 32'(full_alarm), 0);
        check("R7 still full", 32'(mq.size()), DEP);
        // R2/R3 ordered drain of all entries
        for (int i = 0; i < DEP; i++) step("R2", 0, 0, 4'h0, 1);
        check("R3 empty after drain", 32'(rd_valid), 0);

        // R5: stall of exactly LIM ticks
        step("R5", 1, 1, 4'h3, 0);
        step("R5", 1, 1, 4'h3, 0);
        for (int i = 0; i < LIM - 1; i++) step("R5", 1, 0, 4'h0, 0);
        check("R5 no early fire", 32'(wdog_rst), 0);
        step("R5", 1, 0, 4'h0, 0);
        check("R5 fire", 32'(wdog_rst), 1);
        step("R5", 0, 0, 4'h0, 0);
        check("R5 one clock", 32'(wdog_rst), 0);

        // R8: a read clears the stall count
        for (int i = 0; i < LIM - 3; i++) step("R8", 1, 0, 4'h0, 0);
        step("R8", 0, 0, 4'h0, 1);
        step("R8", 1, 1, 4'h6, 0);
        step("R8", 1, 1, 4'h6, 0);
        for (int i = 0; i < LIM - 1; i++) step("R8", 1, 0, 4'h0, 0);
        check("R8 cleared count", 32'(wdog_rst), 0);
        step("R8", 0, 0, 4'h0, 1);

        // mixed sweep against the model
        for (int i = 0; i < 4000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step("R2 sweep", lfsr[0] | lfsr[1], lfsr[2] | lfsr[3],
                 {2'b00, lfsr[5:4]}, (lfsr[8:6] == 3'b000));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule